// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins and turns activity on each of them into a latched request. Every pin has its own trigger setting: falling edge, rising edge, low level, high level or both edges. Each pin is first brought into the clock domain through two flops. After detection, a pending bit per pin holds the event until software clears it.

Software reaches the block through a small word-wide register bus. Through it software programs the trigger kinds, sets a 4-bit priority gate per pin, reads and clears the pending bits, and masks or unmasks pins through separate set and clear ports. A mode register holds one bit that selects individual per-pin handling. The block drives one request line per pin and one line that ORs all of them.

Top module: `xpin_irq_ctrl`

## Requirements
- R1: After reset, every register read returns zero: trigger (address 0), priority (address 1), pending (address 2) and mode (address 5). All pins are masked, and no request output is high.
- R2: The trigger register (address 0) is 32 bits wide and holds one field of SENSE_W bits per pin. The field for pin k starts at bit 32-(k+1)*SENSE_W, so pin 0 is in the top field. The register reads back what was written.
- R3: A change on a pin reaches its pending bit at the third rising clock edge after it is applied. The first two edges fill the synchroniser.
- R4: The edge trigger codes are 0 (falling), 1 (rising) and 4 (both edges). For each of these, the matching transition sets the pending bit, and the transition in the other direction does not. The bit stays set after the pin returns to its idle level.
- R5: The level trigger codes are 2 (low) and 3 (high). The pending bit is set while the pin is at its active level. A clear attempt has no effect while that level persists. A clear attempt succeeds once the pin is inactive.
- R6: Reading address 2 returns pin k's pending bit at bit SRC_W-1-k (default SRC_W=8, so pin 0 is bit 7). A write to address 2 clears every pending bit whose position is written as 0 and leaves the bits written as 1 unchanged.
- R7: If a trigger event and a clearing write to address 2 fall in the same cycle, the pending bit ends up set.
- R8: Writing 1 at bit SRC_W-1-k of address 3 masks pin k. Writing 1 at the same position of address 4 unmasks it. Bits written as 0 change nothing in either register.
- R9: The priority register (address 1) has a 4-bit field per pin, with pin k at bits 31-4k down to 28-4k. A field of zero blocks pin k's request. Any nonzero value lets it through.
- R10: Bit 23 of address 5 selects individual pin handling. While it is 0, all request outputs stay low, but pending bits are still recorded.
- R11: A pin's request output is high exactly when it is pending, unmasked, has a nonzero priority field and individual mode is selected. The combined output is the OR of all per-pin outputs.
- R12: Trigger codes 5 to 15 detect nothing, so no pin transition sets the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | External interrupt pins, asynchronous |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | NUM_PINS | Per-pin request |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
Pending-bit setting by a detected event and pending-bit clearing by a write to the pending register can happen in the same cycle. The bench provokes this by changing a pin and then holding a clearing write so that it is sampled on the third edge, the same edge at which the synchronised event lands. It then reads the pending register and expects the bit to be set. A second collision is checked for the level triggers: a clearing write is issued while the pin is still at its active level, and the bit must survive it.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

   typedef enum logic [3:0] {
      TRIG_FALL = 4'd0,
      TRIG_RISE = 4'd1,
      TRIG_LOW  = 4'd2,
      TRIG_HIGH = 4'd3,
      TRIG_BOTH = 4'd4
   } trig_e;

   localparam logic [2:0] A_TRIG  = 3'd0;
   localparam logic [2:0] A_PRIO  = 3'd1;
   localparam logic [2:0] A_PEND  = 3'd2;
   localparam logic [2:0] A_MSET  = 3'd3;
   localparam logic [2:0] A_MCLR  = 3'd4;
   localparam logic [2:0] A_MODE  = 3'd5;

   localparam int REG_W    = 32;
   localparam int PRIO_W   = 4;
   localparam int MODE_POS = 23;

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] stg0_q;
   logic [W-1:0] stg1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg0_q <= '0;
         stg1_q <= '0;
      end else begin
         stg0_q <= async_i;
         stg1_q <= stg0_q;
      end
   end

   assign sync_o = stg1_q;

`ifndef SYNTHESIS
   a_r3_two_stage : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sync_o == $past(stg0_q)));
`endif
endmodule

// File: rtl/xpin_detect.sv
module xpin_detect
   import xpin_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_s,
   input  logic [3:0] trig,
   input  logic       clr,
   output logic       pend
);
   logic prev_q;
   logic hit;
   logic pend_q;

   always_comb begin
      unique case (trig)
         TRIG_FALL: hit = ~pin_s &  prev_q;
         TRIG_RISE: hit =  pin_s & ~prev_q;
         TRIG_LOW:  hit = ~pin_s;
         TRIG_HIGH: hit =  pin_s;
         TRIG_BOTH: hit =  pin_s ^  prev_q;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         pend_q <= hit | (pend_q & ~clr);
      end
   end

   assign pend = pend_q;

`ifndef SYNTHESIS
   a_r7_event_beats_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr) |=> pend);
   a_r4_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);
   a_r5_level_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (trig == TRIG_HIGH && pin_s && clr) |=> pend);
   a_r12_no_code_no_set : assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && trig > 4'd4) |=> !pend);
`endif
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs
   import xpin_pkg::*;
#(
   parameter int NUM_PINS     = 8,
   parameter int SRC_W        = 8,
   parameter bit HAS_MODE_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [2:0]          bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pend,
   output logic [REG_W-1:0]    trig_reg,
   output logic [REG_W-1:0]    prio_reg,
   output logic [NUM_PINS-1:0] mask,
   output logic                indiv_mode,
   output logic [NUM_PINS-1:0] clr
);
   logic wr;
   logic wr_trig, wr_prio, wr_pend, wr_mset, wr_mclr, wr_mode;
   logic [REG_W-1:0] pend_view;
   logic [REG_W-1:0] mode_view;

   assign wr      = bus_en & bus_we;
   assign wr_trig = wr && (bus_addr == A_TRIG);
   assign wr_prio = wr && (bus_addr == A_PRIO);
   assign wr_pend = wr && (bus_addr == A_PEND);
   assign wr_mset = wr && (bus_addr == A_MSET);
   assign wr_mclr = wr && (bus_addr == A_MCLR);
   assign wr_mode = wr && (bus_addr == A_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_reg <= '0;
         prio_reg <= '0;
      end else begin
         if (wr_trig) trig_reg <= bus_wdata;
         if (wr_prio) prio_reg <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '1;
      end else begin
         for (int k = 0; k < NUM_PINS; k++) begin
            if (wr_mset && bus_wdata[SRC_W-1-k])
               mask[k] <= 1'b1;
            else if (wr_mclr && bus_wdata[SRC_W-1-k])
               mask[k] <= 1'b0;
         end
      end
   end

   generate
      if (HAS_MODE_REG) begin : g_mode
         logic mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mode_q <= 1'b0;
            else if (wr_mode) mode_q <= bus_wdata[MODE_POS];
         end
         assign indiv_mode = mode_q;
         always_comb begin
            mode_view = '0;
            mode_view[MODE_POS] = mode_q;
         end
      end else begin : g_nomode
         assign indiv_mode = 1'b1;
         assign mode_view  = '0;
      end
   endgenerate

   always_comb begin
      pend_view = '0;
      for (int k = 0; k < NUM_PINS; k++) begin
         pend_view[SRC_W-1-k] = pend[k];
         clr[k] = wr_pend & ~bus_wdata[SRC_W-1-k];
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_TRIG:  bus_rdata = trig_reg;
         A_PRIO:  bus_rdata = prio_reg;
         A_PEND:  bus_rdata = pend_view;
         A_MODE:  bus_rdata = mode_view;
         default: bus_rdata = '0;
      endcase
   end

`ifndef SYNTHESIS
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
      a_r8_set_masks : assert property (@(posedge clk) disable iff (!rst_n)
         (wr_mset && bus_wdata[SRC_W-1-g]) |=> mask[g]);
      a_r8_clear_unmasks : assert property (@(posedge clk) disable iff (!rst_n)
         (wr_mclr && bus_wdata[SRC_W-1-g] && !bus_wdata[SRC_W-1-g] == 1'b0
          && !(wr_mset)) |=> !mask[g]);
      a_r8_zero_no_effect : assert property (@(posedge clk) disable iff (!rst_n)
         ((wr_mset || wr_mclr) && !bus_wdata[SRC_W-1-g]) |=> $stable(mask[g]));
   end
`endif
endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
   import xpin_pkg::*;
#(
   parameter int NUM_PINS     = 8,
   parameter int SENSE_W      = 4,
   parameter int SRC_W        = 8,
   parameter bit HAS_MODE_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [2:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PINS-1:0] irq_o,
   output logic                irq_any_o
);
   localparam int TRIG_FIELDS = REG_W / SENSE_W;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
         $error("NUM_PINS must lie in 1..8");
      end
      if (SENSE_W != 2 && SENSE_W != 4) begin : g_bad_sense
         $error("SENSE_W must be 2 or 4");
      end
      if (SRC_W != 8 && SRC_W != 32) begin : g_bad_src
         $error("SRC_W must be 8 or 32");
      end
      if (NUM_PINS > TRIG_FIELDS) begin : g_bad_fit
         $error("trigger fields do not fit");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_s;
   logic [NUM_PINS-1:0] pend;
   logic [NUM_PINS-1:0] mask;
   logic [NUM_PINS-1:0] clr;
   logic [REG_W-1:0]    trig_reg;
   logic [REG_W-1:0]    prio_reg;
   logic                indiv_mode;
   logic [NUM_PINS-1:0] prio_open;

   xpin_sync #(.W(NUM_PINS)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (pin_s)
   );

   xpin_regs #(
      .NUM_PINS     (NUM_PINS),
      .SRC_W        (SRC_W),
      .HAS_MODE_REG (HAS_MODE_REG)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pend       (pend),
      .trig_reg   (trig_reg),
      .prio_reg   (prio_reg),
      .mask       (mask),
      .indiv_mode (indiv_mode),
      .clr        (clr)
   );

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      logic [SENSE_W-1:0] field;
      logic [3:0]         code;

      assign field = trig_reg[REG_W-(k+1)*SENSE_W +: SENSE_W];

      if (SENSE_W == 4) begin : g_w4
         assign code = field;
      end else begin : g_w2
         assign code = {2'b00, field};
      end

      assign prio_open[k] = |prio_reg[REG_W-(k+1)*PRIO_W +: PRIO_W];

      xpin_detect det_i (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_s (pin_s[k]),
         .trig  (code),
         .clr   (clr[k]),
         .pend  (pend[k])
      );

      assign irq_o[k] = pend[k] & ~mask[k] & prio_open[k] & indiv_mode;

`ifndef SYNTHESIS
      a_r9_prio_zero_blocks : assert property (@(posedge clk) disable iff (!rst_n)
         (prio_reg[REG_W-(k+1)*PRIO_W +: PRIO_W] == 4'd0) |-> !irq_o[k]);
      a_r8_masked_silent : assert property (@(posedge clk) disable iff (!rst_n)
         mask[k] |-> !irq_o[k]);
`endif
   end

   assign irq_any_o = |irq_o;

`ifndef SYNTHESIS
   a_r10_mode_gate : assert property (@(posedge clk) disable iff (!rst_n)
      !indiv_mode |-> (irq_o == '0));
   a_r11_any_has_source : assert property (@(posedge clk) disable iff (!rst_n)
      irq_any_o |-> (pend != '0));
`endif
endmodule

// File: tb/xpin_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module xpin_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin = '0;
   logic        en = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  irq;
   logic        irq_any;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xpin_irq_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin),
      .bus_en    (en),
      .bus_we    (we),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_o     (irq),
      .irq_any_o (irq_any)
   );

   // {code[3:0], start level, end level, expected pending} for pin 2
   localparam logic [6:0] VEC [12] = '{
      {4'd0, 1'b1, 1'b0, 1'b1}, {4'd0, 1'b0, 1'b1, 1'b0},
      {4'd1, 1'b0, 1'b1, 1'b1}, {4'd1, 1'b1, 1'b0, 1'b0},
      {4'd4, 1'b0, 1'b1, 1'b1}, {4'd4, 1'b1, 1'b0, 1'b1},
      {4'd2, 1'b1, 1'b0, 1'b1}, {4'd2, 1'b1, 1'b1, 1'b0},
      {4'd3, 1'b0, 1'b1, 1'b1}, {4'd3, 1'b0, 1'b0, 1'b0},
      {4'd5, 1'b0, 1'b1, 1'b0}, {4'd5, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      en = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      en = 1'b0; we = 1'b0;
   endtask

   task automatic br(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; en = 1'b1; we = 1'b0;
      #1 d = rdata;
      en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      br(3'd0, rd); chk("R1 trig", rd, 32'h0);
      br(3'd1, rd); chk("R1 prio", rd, 32'h0);
      br(3'd2, rd); chk("R1 pend", rd, 32'h0);
      br(3'd5, rd); chk("R1 mode", rd, 32'h0);
      chk("R1 irq", {23'd0, irq_any, irq}, 32'h0);

      // R2 field layout and readback
      bw(3'd0, 32'h4000_0002);
      br(3'd0, rd); chk("R2 readback", rd, 32'h4000_0002);
      bw(3'd0, 32'h0);

      bw(3'd5, 32'h0080_0000);
      br(3'd5, rd); chk("R10 mode bit 23", rd, 32'h0080_0000);
      bw(3'd1, 32'hFFFF_FFFF);

      // R4 R5 R12 table walk on pin 2 (field bits 23:20, pending bit 5)
      foreach (VEC[i]) begin
         bw(3'd0, {8'd0, VEC[i][6:3], 20'd0});
         pin[2] = VEC[i][2];
         idle(5);
         bw(3'd2, 32'h0);
         idle(2);
         pin[2] = VEC[i][1];
         idle(5);
         br(3'd2, rd);
         chk($sformatf("R4/R5/R12 vec%0d code%0d", i, VEC[i][6:3]),
             {31'd0, rd[5]}, {31'd0, VEC[i][0]});
      end
      pin[2] = 1'b0;
      bw(3'd0, 32'h0);
      idle(5);
      bw(3'd2, 32'h0);

      // R4 sticky: rising on pin 2, pin returns low, bit stays
      bw(3'd0, 32'h0010_0000);
      pin[2] = 1'b1; idle(5); pin[2] = 1'b0; idle(5);
      br(3'd2, rd); chk("R4 sticky", {31'd0, rd[5]}, 32'h1);
      bw(3'd2, 32'h0);

      // R6 bit positions and selective clear
      bw(3'd0, 32'h1000_0001);
      pin[0] = 1'b1; pin[7] = 1'b1;
      idle(5);
      br(3'd2, rd); chk("R6 positions", rd, 32'h0000_0081);
      bw(3'd2, 32'h0000_00FE);
      br(3'd2, rd); chk("R6 selective clear", rd, 32'h0000_0080);
      bw(3'd2, 32'h0);
      br(3'd2, rd); chk("R6 clear all", rd, 32'h0);
      pin[0] = 1'b0; pin[7] = 1'b0;
      idle(5);

      // R5 level high, clear while active
      bw(3'd0, 32'h3000_0000);
      pin[0] = 1'b1; idle(5);
      bw(3'd2, 32'h0);
      br(3'd2, rd); chk("R5 clear while active", rd, 32'h0000_0080);
      pin[0] = 1'b0; idle(5);
      bw(3'd2, 32'h0);
      br(3'd2, rd); chk("R5 clear when inactive", rd, 32'h0);

      // R8 R9 R10 R11 gating, pin 0 pending via rising edge
      bw(3'd0, 32'h1000_0000);
      pin[0] = 1'b1; idle(5); pin[0] = 1'b0; idle(5);
      chk("R8 masked after reset", {31'd0, irq[0]}, 32'h0);
      bw(3'd4, 32'h0000_0080);
      chk("R8 unmask", {31'd0, irq[0]}, 32'h1);
      chk("R11 any", {31'd0, irq_any}, 32'h1);
      bw(3'd3, 32'h0000_007F);
      chk("R8 zero bit ignored on set", {31'd0, irq[0]}, 32'h1);
      bw(3'd1, 32'h0FFF_FFFF);
      chk("R9 zero field blocks", {31'd0, irq[0]}, 32'h0);
      chk("R11 any follows", {31'd0, irq_any}, 32'h0);
      bw(3'd1, 32'h1FFF_FFFF);
      chk("R9 nonzero passes", {31'd0, irq[0]}, 32'h1);
      bw(3'd5, 32'h0);
      chk("R10 mode clear gates", {31'd0, irq[0]}, 32'h0);
      br(3'd2, rd); chk("R10 pending kept", rd, 32'h0000_0080);
      bw(3'd5, 32'h0080_0000);
      chk("R10 mode set passes", {31'd0, irq[0]}, 32'h1);
      bw(3'd3, 32'h0000_0080);
      chk("R8 mask set", {31'd0, irq[0]}, 32'h0);
      bw(3'd4, 32'h0);
      chk("R8 zero bit ignored on clear", {31'd0, irq[0]}, 32'h0);
      bw(3'd2, 32'h0);

      // R3 latency on pin 1 (field bits 27:24)
      bw(3'd0, 32'h0100_0000);
      bw(3'd4, 32'h0000_0040);
      idle(2);
      pin[1] = 1'b1;
      idle(2);
      chk("R3 not yet after two edges", {31'd0, irq[1]}, 32'h0);
      idle(1);
      chk("R3 pending on third edge", {31'd0, irq[1]}, 32'h1);
      pin[1] = 1'b0;
      bw(3'd2, 32'h0);

      // R7 event and clear in the same cycle, pin 3 (field 19:16, bit 4)
      bw(3'd0, 32'h0001_0000);
      idle(3);
      pin[3] = 1'b1;
      idle(2);
      en = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'h0;
      idle(1);
      en = 1'b0; we = 1'b0;
      br(3'd2, rd); chk("R7 event wins", {31'd0, rd[4]}, 32'h1);
      bw(3'd2, 32'h0);
      br(3'd2, rd); chk("R7 later clear works", {31'd0, rd[4]}, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule